// File: doc/BRIEF.md
# Daisy-Chain Converter Readback Controller

This block is the host side of a chain of serial 16-bit converters wired as a shift chain. The output of each converter feeds the serial input of the next one, and the first converter in the chain has its serial input tied low. The block drives the shared convert line and the shared serial clock. It launches a conversion in every converter at once. It then waits for the results, either for a fixed worst-case conversion time or until a busy start bit shows up on the data line from the converter nearest the host. After that it clocks all words out of the chain and splits the serial stream into one parallel word per converter.

A one-cycle `start` request begins a frame. The `busyMode` bit is sampled together with that request and selects how completion is detected. The controller tells the whole chain which mode to use through the serial clock level it holds around the rising edge of the convert line. When the last bit has arrived, the convert line drops, the words appear on `dataOut` and `dataValid` pulses for one cycle. The number of converters, the serial clock divider and all timing windows, counted in system clock cycles, are parameters.

Top module: `adc_chain_reader`

## Requirements
- R1: While reset is active and after it is released, `adcCnv`, `adcSck` and `dataValid` are low and `dataOut` is all zeros until the first frame completes.
- R2: The `adcSck` level at the rising edge of `adcCnv` equals the `busyMode` value sampled with the accepted `start` (1 = busy start bit expected). That level is held for at least SETUP_CYC cycles before the edge and at least HOLD_CYC cycles after it.
- R3: `adcCnv` stays high from its rising edge until the last serial clock falling edge of the frame. It falls in the same cycle as that edge, and `adcSck` is low once the frame ends.
- R4: Without busy, the first `adcSck` rising edge comes no earlier than CONV_CYC cycles after the `adcCnv` rising edge.
- R5: With busy, no `adcSck` rising edge occurs before `adcSdo` has gone high. The bit sampled on the first rising edge (the start bit) is discarded.
- R6: A frame has exactly 16×NUM_DEV serial clock rising edges without busy and 16×NUM_DEV+1 with busy. Consecutive rising edges are SCK_DIV cycles apart, and `adcSck` is low whenever no frame is running.
- R7: `adcSdo` is sampled on each `adcSck` rising edge, and every word is MSB first. The converter nearest the host delivers its word first. The word of chain position k (k = 0 nearest the host) appears at `dataOut[16k+15:16k]`.
- R8: `dataValid` is a single-cycle pulse. It is asserted in the cycle in which `adcCnv` is already low, and `dataOut` holds the new words while it is high.
- R9: Two rising edges of `adcCnv` are at least CYC_MIN cycles apart. A `start` that would break this is held off, not dropped.
- R10: A `start` that arrives while a frame is running is ignored. It causes no extra conversion and does not change the busy choice of the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle frame request |
| busyMode | input | 1 | Completion method, sampled with start: 1 = busy start bit, 0 = fixed wait |
| adcSdo | input | 1 | Serial data from the converter nearest the host |
| adcCnv | output | 1 | Convert line shared by all converters |
| adcSck | output | 1 | Serial clock shared by all converters |
| dataOut | output | 16×NUM_DEV | Collected words, position k at bits 16k+15:16k |
| dataValid | output | 1 | One-cycle strobe marking new dataOut |

## Verification
Two functions can meet in one cycle: a frame finishing with its valid strobe, and the acceptance of a new request. The bench provokes this by raising `start` in exactly the cycle `dataValid` is high, after a busy frame short enough that the minimum spacing of convert edges has not yet passed. It judges the result by two things: the second frame must still arrive with correct words, and its convert edge must keep the required distance from the previous one. The bench also mixes busy and fixed-wait frames with all-zero and all-one words next to each other. A start bit that is not discarded would then shift every word it is compared against.

// File: rtl/adc_chain_pkg.sv
package adc_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HOLD,
    ST_CONV,
    ST_XFER
  } seqState_t;

  typedef struct packed {
    logic clear;
    logic skipLead;
    logic sample;
    logic publish;
  } dpCtl_t;

endpackage

// File: rtl/adc_chain_ctrl.sv
module adc_chain_ctrl
  import adc_chain_pkg::*;
#(
  parameter int NUM_DEV   = 3,
  parameter int WORD_W    = 16,
  parameter int SCK_DIV   = 4,
  parameter int CONV_CYC  = 100,
  parameter int CYC_MIN   = 150,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   busyMode,
  input  logic   adcSdo,
  output logic   adcCnv,
  output logic   adcSck,
  output dpCtl_t dpCtl
);

  localparam int HALF      = SCK_DIV / 2;
  localparam int BASE_BITS = NUM_DEV * WORD_W;
  localparam int BIT_W     = $clog2(BASE_BITS + 2);
  localparam int PH_W      = $clog2(SCK_DIV);
  localparam int GAP_W     = $clog2(CYC_MIN + 1);
  localparam int STEP_W    = $clog2(SETUP_CYC + HOLD_CYC + CONV_CYC + 2);

  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(SCK_DIV - 1);
  localparam logic [PH_W-1:0]   PH_RISE   = PH_W'(HALF - 1);
  localparam logic [BIT_W-1:0]  LAST_PLAIN = BIT_W'(BASE_BITS - 1);
  localparam logic [BIT_W-1:0]  LAST_BUSY  = BIT_W'(BASE_BITS);
  localparam logic [GAP_W-1:0]  GAP_MIN   = GAP_W'(CYC_MIN);
  localparam logic [STEP_W-1:0] SET_LAST  = STEP_W'(SETUP_CYC - 1);
  localparam logic [STEP_W-1:0] HOLD_LAST = STEP_W'(HOLD_CYC - 1);
  localparam logic [STEP_W-1:0] CONV_END  = STEP_W'(CONV_CYC);

  seqState_t         state;
  logic              busyQ;
  logic              cnvQ;
  logic              sckQ;
  logic [STEP_W-1:0] stepCnt;
  logic [PH_W-1:0]   phaseCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [GAP_W-1:0]  gapCnt;

  logic gapOk;
  logic setupDone;
  logic cnvRiseNow;
  logic convLeave;
  logic lastBit;
  logic phaseEnd;

  assign gapOk      = (gapCnt >= GAP_MIN);
  assign setupDone  = (stepCnt >= SET_LAST);
  assign cnvRiseNow = (state == ST_SETUP) && setupDone && gapOk;
  assign convLeave  = (state == ST_CONV) && (busyQ ? adcSdo : (stepCnt >= CONV_END));
  assign lastBit    = (bitCnt == (busyQ ? LAST_BUSY : LAST_PLAIN));
  assign phaseEnd   = (phaseCnt == PH_LAST);

  always_comb begin
    dpCtl          = '0;
    dpCtl.clear    = convLeave;
    dpCtl.skipLead = busyQ;
    dpCtl.sample   = (state == ST_XFER) && (phaseCnt == PH_RISE);
    dpCtl.publish  = (state == ST_XFER) && phaseEnd && lastBit;
  end

  // spacing counter between convert edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= GAP_MIN;
    end else if (cnvRiseNow) begin
      gapCnt <= GAP_W'(1);
    end else if (!gapOk) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      busyQ    <= 1'b0;
      cnvQ     <= 1'b0;
      sckQ     <= 1'b0;
      stepCnt  <= '0;
      phaseCnt <= '0;
      bitCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            busyQ   <= busyMode;
            sckQ    <= busyMode;
            stepCnt <= '0;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnvRiseNow) begin
            cnvQ    <= 1'b1;
            stepCnt <= '0;
            state   <= ST_HOLD;
          end else if (!setupDone) begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_HOLD: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt >= HOLD_LAST) begin
            sckQ  <= 1'b0;
            state <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (!busyQ) begin
            stepCnt <= stepCnt + 1'b1;
          end
          if (convLeave) begin
            phaseCnt <= '0;
            bitCnt   <= '0;
            state    <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            sckQ     <= 1'b0;
            if (lastBit) begin
              cnvQ  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
            if (phaseCnt == PH_RISE) begin
              sckQ <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign adcCnv = cnvQ;
  assign adcSck = sckQ;

  // mode level on the clock line at the convert edge
  p_mode_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcCnv) |-> (adcSck == busyQ));

  p_hold_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && $past(state) == ST_HOLD) |-> $stable(adcSck));

  p_cnv_through_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER) |-> adcCnv);

  p_busy_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && busyQ && !adcSdo) |=> !adcSck);

  p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !adcSck);

  p_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcCnv) |-> $past(gapOk));

  p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> $stable(busyQ));

endmodule

// File: rtl/adc_chain_datapath.sv
module adc_chain_datapath
  import adc_chain_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter int WORD_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    dpCtl,
  input  logic                      sdoIn,
  output logic [NUM_DEV*WORD_W-1:0] dataOut,
  output logic                      dataValid
);

  localparam int IDX_W  = $clog2(NUM_DEV + 1);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] WORD_END = IDX_W'(NUM_DEV);
  localparam logic [BIT_W-1:0] BIT_TOP  = BIT_W'(WORD_W - 1);

  logic             skipQ;
  logic [IDX_W-1:0] wordIdx;
  logic [BIT_W-1:0] bitIdx;
  logic             writeEn;
  logic [BIT_W-1:0] bitPos;
  logic             validQ;

  assign writeEn = dpCtl.sample && !skipQ;
  assign bitPos  = BIT_TOP - bitIdx;

  // demultiplex position tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      skipQ   <= 1'b0;
      wordIdx <= '0;
      bitIdx  <= '0;
    end else if (dpCtl.clear) begin
      skipQ   <= dpCtl.skipLead;
      wordIdx <= '0;
      bitIdx  <= '0;
    end else if (dpCtl.sample) begin
      if (skipQ) begin
        skipQ <= 1'b0;
      end else if (bitIdx == BIT_TOP) begin
        bitIdx  <= '0;
        wordIdx <= wordIdx + 1'b1;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else begin
      validQ <= dpCtl.publish;
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : gWord
    logic [WORD_W-1:0] capWord;
    logic [WORD_W-1:0] outWord;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        capWord <= '0;
      end else if (writeEn && (wordIdx == IDX_W'(g))) begin
        capWord[bitPos] <= sdoIn;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outWord <= '0;
      end else if (dpCtl.publish) begin
        outWord <= capWord;
      end
    end

    assign dataOut[g*WORD_W +: WORD_W] = outWord;
  end

  assign dataValid = validQ;

  p_full_frame_r6: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.publish |-> (wordIdx == WORD_END && bitIdx == '0 && !skipQ));

  p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |-> (wordIdx < WORD_END));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader
  import adc_chain_pkg::*;
#(
  parameter int NUM_DEV   = 3,
  parameter int WORD_W    = 16,
  parameter int SCK_DIV   = 4,
  parameter int CONV_CYC  = 100,
  parameter int CYC_MIN   = 150,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      busyMode,
  input  logic                      adcSdo,
  output logic                      adcCnv,
  output logic                      adcSck,
  output logic [NUM_DEV*WORD_W-1:0] dataOut,
  output logic                      dataValid
);

  dpCtl_t dpCtl;

  adc_chain_ctrl #(
    .NUM_DEV  (NUM_DEV),
    .WORD_W   (WORD_W),
    .SCK_DIV  (SCK_DIV),
    .CONV_CYC (CONV_CYC),
    .CYC_MIN  (CYC_MIN),
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .busyMode(busyMode),
    .adcSdo  (adcSdo),
    .adcCnv  (adcCnv),
    .adcSck  (adcSck),
    .dpCtl   (dpCtl)
  );

  adc_chain_datapath #(
    .NUM_DEV(NUM_DEV),
    .WORD_W (WORD_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtl    (dpCtl),
    .sdoIn    (adcSdo),
    .dataOut  (dataOut),
    .dataValid(dataValid)
  );

endmodule

// File: tb/tb_adc_chain_reader.sv
`timescale 1ns/1ps
module tb_adc_chain_reader;

  localparam int NDEV  = 2;
  localparam int WW    = 16;
  localparam int SDIV  = 2;
  localparam int CONVC = 40;
  localparam int CYCM  = 150;
  localparam int SETC  = 2;
  localparam int HOLDC = 2;
  localparam int SLEN  = NDEV * WW + 1;
  localparam real TCK  = 5.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busyMode = 1'b0;
  logic adcSdo;
  logic adcCnv;
  logic adcSck;
  logic [NDEV*WW-1:0] dataOut;
  logic dataValid;

  adc_chain_reader #(
    .NUM_DEV(NDEV), .WORD_W(WW), .SCK_DIV(SDIV), .CONV_CYC(CONVC),
    .CYC_MIN(CYCM), .SETUP_CYC(SETC), .HOLD_CYC(HOLDC)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .busyMode(busyMode),
    .adcSdo(adcSdo), .adcCnv(adcCnv), .adcSck(adcSck),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic               busy;
    logic [NDEV*WW-1:0] words;
    int                 delayNs;
  } frame_t;

  frame_t modelQ[$];
  frame_t expQ[$];
  frame_t cur;

  int checks = 0;
  int errors = 0;
  int issued = 0;
  int validCount = 0;
  bit prevValid = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // chain model: nearest converter first, optional start bit ahead
  logic [SLEN-1:0] streamV = '0;
  int      ptr = 0;
  int      slen = 0;
  bit      convDone = 1'b0;
  int      rises = 0;
  realtime tRise = 0.0;
  realtime tPrevRise = -1.0e9;
  realtime tDone = 0.0;
  realtime tLastSck = -1.0e9;
  realtime tPrevSckRise = 0.0;

  assign adcSdo = (convDone && ptr < slen) ? streamV[ptr] : 1'b0;

  always @(posedge adcCnv) begin
    tRise = $realtime;
    check(tRise - tPrevRise >= CYCM * TCK - 0.01, "R9", "convert edge spacing ns",
          longint'(tRise - tPrevRise), longint'(CYCM * TCK));
    tPrevRise = tRise;
    if (modelQ.size() == 0) begin
      check(1'b0, "R10", "unexpected conversion", 1, 0);
      cur = '0;
    end else begin
      cur = modelQ.pop_front();
    end
    check(adcSck == cur.busy, "R2", "SCK level at convert edge", adcSck, cur.busy);
    check(tRise - tLastSck >= SETC * TCK - 0.01, "R2", "SCK setup ns",
          longint'(tRise - tLastSck), longint'(SETC * TCK));
    slen = 0;
    if (cur.busy) begin
      streamV[0] = 1'b1;
      slen = 1;
    end
    for (int k = 0; k < NDEV; k++) begin
      for (int b = WW - 1; b >= 0; b--) begin
        streamV[slen] = cur.words[k*WW + b];
        slen++;
      end
    end
    ptr = 0;
    rises = 0;
    convDone = 1'b0;
    #(cur.delayNs);
    convDone = 1'b1;
    tDone = $realtime;
  end

  always @(posedge adcSck) begin
    if (adcCnv) begin
      rises++;
      if (rises == 1) begin
        if (cur.busy)
          check(convDone && ($realtime > tDone), "R5", "first clock after busy bit",
                longint'(convDone), 1);
        else
          check($realtime - tRise >= CONVC * TCK - 0.01, "R4", "wait before first clock ns",
                longint'($realtime - tRise), longint'(CONVC * TCK));
      end else begin
        check(($realtime - tPrevSckRise) > SDIV * TCK - 0.01 &&
              ($realtime - tPrevSckRise) < SDIV * TCK + 0.01, "R6", "SCK period ns",
              longint'($realtime - tPrevSckRise), longint'(SDIV * TCK));
      end
      tPrevSckRise = $realtime;
    end
    tLastSck = $realtime;
  end

  always @(negedge adcSck) begin
    if (adcCnv) begin
      if (convDone) ptr++;
      else check($realtime - tRise >= HOLDC * TCK - 0.01, "R2", "SCK hold ns",
                 longint'($realtime - tRise), longint'(HOLDC * TCK));
    end
    tLastSck = $realtime;
  end

  always @(negedge adcCnv) begin
    #1;
    check(!adcSck && !adcCnv, "R3", "SCK low after convert falls", adcSck, 0);
    check(rises == NDEV * WW + int'(cur.busy), "R6", "clock count", rises,
          NDEV * WW + int'(cur.busy));
    convDone = 1'b0;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (prevValid)
        check(!dataValid, "R8", "valid lasts one cycle", dataValid, 0);
      if (dataValid) begin
        frame_t e;
        validCount++;
        check(!adcCnv, "R8", "convert low with valid", adcCnv, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R10", "result without request", 1, 0);
        end else begin
          e = expQ.pop_front();
          for (int k = 0; k < NDEV; k++)
            check(dataOut[k*WW +: WW] == e.words[k*WW +: WW], "R7", "word at chain position",
                  dataOut[k*WW +: WW], e.words[k*WW +: WW]);
        end
      end
    end
    prevValid = dataValid;
  end

  task automatic issue(input bit busy, input logic [NDEV*WW-1:0] words, input int delayNs);
    frame_t f;
    f.busy = busy;
    f.words = words;
    f.delayNs = delayNs;
    modelQ.push_back(f);
    expQ.push_back(f);
    issued++;
    start = 1'b1;
    busyMode = busy;
    @(negedge clk);
    start = 1'b0;
    busyMode = 1'b0;
  endtask

  task automatic waitValid();
    do @(negedge clk); while (!dataValid);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!adcCnv && !adcSck && !dataValid, "R1", "outputs in reset",
          {adcCnv, adcSck, dataValid}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!adcCnv && !adcSck && !dataValid, "R1", "outputs after reset",
          {adcCnv, adcSck, dataValid}, 0);
    check(dataOut == '0, "R1", "dataOut after reset", dataOut, 0);

    // fixed wait, mixed patterns (R4, R7)
    issue(1'b0, {16'hC3A5, 16'h5A3C}, 151);
    waitValid();
    // busy mode, start bit dropped (R5)
    issue(1'b1, {16'h8001, 16'h1234}, 301);
    waitValid();
    // busy with word 0 all zero: leftover start bit would show as 8000
    issue(1'b1, {16'hFFFF, 16'h0000}, 456);
    waitValid();
    issue(1'b0, {16'h0000, 16'hFFFF}, 91);
    waitValid();

    // R10: request during a running frame with the other mode
    issue(1'b0, {16'h0F0F, 16'hF00F}, 201);
    repeat (60) @(negedge clk);
    start = 1'b1;
    busyMode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busyMode = 1'b0;
    waitValid();
    repeat (200) @(negedge clk);
    check(!adcCnv && modelQ.size() == 0, "R10", "no extra conversion", adcCnv, 0);

    // R9: new request in the very cycle of the valid strobe
    issue(1'b1, {16'h2468, 16'h7531}, 126);
    waitValid();
    issue(1'b0, {16'hAAAA, 16'h5555}, 121);
    waitValid();

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R10", "pending results", expQ.size(), 0);
    check(validCount == issued, "R8", "valid strobe count", validCount, issued);
    finishRun();
  end

endmodule